// File: doc/BRIEF.md
# Bulk Transmit Packet Splitter

This block sits between a transmit buffer that software fills and the packet engine of one bulk IN endpoint. Software stores one large block at buffer offset 0. It writes a 16-bit max-packet word that holds a per-packet payload size and a multiplier, then pulses `start`. The block checks the word. If the word is legal, it reads the buffer byte by byte and presents the block to the packet engine as a series of bus packets, each exactly one payload long. It waits for the engine to acknowledge each packet before it opens the next one. A retry request from the engine resends the current packet from its first byte.

Software sees the whole operation as a single packet. `busy` stays high for the full transfer, and `tx_done` pulses once, only after the engine has acknowledged the final piece. An illegal word sets `cfg_err`, and no packet is sent.

Top module: `bulk_tx_splitter`

## Requirements
- R1: The payload size is taken from bits [10:0] of `cfg_maxp` and the multiplier from bits [15:11]. A multiplier of 0 or 1 sends one packet of payload bytes. A multiplier M of 2 or more sends M packets, each exactly payload bytes long.
- R2: Byte k of packet p is read from buffer address p*payload+k, starting at address 0. `pkt_last` is high exactly with the final byte of each packet.
- R3: When the multiplier is 2 or more and `cfg_bulk` is low, `start` sets `cfg_err` and no packet is sent.
- R4: When the multiplier is 2 or more, any payload other than 8, 16, 32 or 64 sets `cfg_err` and no packet is sent.
- R5: A payload of 0, or a packet count times payload larger than FIFO_DEPTH, sets `cfg_err`. On any error `busy` stays low. `cfg_err` holds its value until the next accepted `start`, which clears it when that word is legal.
- R6: After the final byte of a packet, `pkt_valid` stays low until `pkt_ack`. An ack for a packet that is not the last one opens the next packet.
- R7: `pkt_retry` while waiting for the ack resends the current packet from its first byte. If `pkt_ack` and `pkt_retry` arrive in the same cycle, the ack takes priority.
- R8: `tx_done` is a one-cycle pulse, raised only in the cycle after the ack of the final packet. `busy` is low in that same cycle.
- R9: `start` is ignored while `busy` is high. The configuration in use is the one captured when the transfer was accepted.
- R10: After reset, `busy`, `cfg_err`, `tx_done` and `pkt_valid` are low. A reset during a transfer abandons it.
- R11: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high and `fifo_rd_addr` holds, so the presented byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_maxp | input | 16 | Payload [10:0] and multiplier [15:11] |
| cfg_bulk | input | 1 | Endpoint is configured as bulk |
| start | input | 1 | Software start strobe |
| busy | output | 1 | Transfer in progress |
| cfg_err | output | 1 | Last start word was illegal |
| tx_done | output | 1 | Single completion pulse |
| fifo_rd_addr | output | $clog2(FIFO_DEPTH) | Buffer read address |
| fifo_rd_data | input | 8 | Buffer byte at fifo_rd_addr (asynchronous read) |
| pkt_valid | output | 1 | Byte presented to the packet engine |
| pkt_data | output | 8 | Presented byte |
| pkt_last | output | 1 | Final byte of the current packet |
| pkt_ready | input | 1 | Engine accepts the presented byte |
| pkt_ack | input | 1 | Engine reports the packet delivered |
| pkt_retry | input | 1 | Engine asks for the current packet again |

## Verification
The assertions check the handshake rules on every cycle:
- a stalled byte stays presented;
- `pkt_last` never appears without `pkt_valid`;
- a closing byte is followed by a silent cycle;
- `tx_done` is a lone pulse with `busy` low;
- an error never comes with `busy`;
- nothing is presented while idle.

The bench scenarios show the rest. They cover the byte order across packets, the packet count and length for each multiplier, and the error classes. They also cover resending after a retry, ignoring `start` mid-transfer, and abandoning a transfer on reset.

// File: rtl/bts_pkg.sv
// Shared widths, state type and payload rule for the bulk transmit splitter.
// Assumes the 16-bit max-packet word layout: payload low, multiplier high.
package bts_pkg;
    localparam int CFG_W  = 16;
    localparam int PAY_W  = 11;
    localparam int MUL_W  = CFG_W - PAY_W;
    localparam int TOT_W  = CFG_W;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT
    } bts_state_e;

    // True when a split payload is one of the sizes a bulk packet may take.
    function automatic logic split_payload_ok(input logic [PAY_W-1:0] p);
        return (p == 11'd8) || (p == 11'd16) || (p == 11'd32) || (p == 11'd64);
    endfunction
endpackage

// File: rtl/bts_cfg_decode.sv
// Decodes the max-packet word into payload and packet count and judges it legal.
// Assumes the check is used only at the moment a start is accepted.
module bts_cfg_decode
    import bts_pkg::*;
#(
    parameter int FIFO_DEPTH = 512
) (
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             is_bulk,
    output logic [PAY_W-1:0] payload,
    output logic [MUL_W-1:0] pkt_count,
    output logic             cfg_bad
);
    logic [MUL_W-1:0] mult_raw;
    logic             split;
    logic [TOT_W-1:0] total;
    logic             too_big;
    logic             split_bad;

    // Field split, effective count and legality of the requested transfer.
    always_comb begin
        payload   = cfg_word[PAY_W-1:0];
        mult_raw  = cfg_word[CFG_W-1:PAY_W];
        split     = mult_raw > MUL_W'(1);
        pkt_count = split ? mult_raw : MUL_W'(1);
        total     = TOT_W'(pkt_count) * TOT_W'(payload);
        too_big   = 32'(total) > 32'(FIFO_DEPTH);
        split_bad = split && (!is_bulk || !split_payload_ok(payload));
        cfg_bad   = (payload == '0) || too_big || split_bad;
    end
endmodule

// File: rtl/bts_addr_gen.sv
// Keeps the packet base address and the byte offset inside the packet.
// Assumes a legal transfer never runs past the buffer depth.
module bts_addr_gen
    import bts_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PAY_W-1:0] payload_in,
    input  logic             beat,
    input  logic             rewind,
    input  logic             advance,
    output logic [AW-1:0]    addr,
    output logic             last_beat
);
    logic [AW-1:0]    base_q;
    logic [PAY_W-1:0] off_q;
    logic [PAY_W-1:0] payload_q;

    // Base and offset update: restart, next packet, resend or next byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            off_q     <= '0;
            payload_q <= '0;
        end else if (load) begin
            base_q    <= '0;
            off_q     <= '0;
            payload_q <= payload_in;
        end else if (advance) begin
            base_q <= base_q + AW'(payload_q);
            off_q  <= '0;
        end else if (rewind) begin
            off_q <= '0;
        end else if (beat) begin
            off_q <= off_q + PAY_W'(1);
        end
    end

    // Current read address and end-of-packet flag.
    always_comb begin
        addr      = base_q + AW'(off_q);
        last_beat = (off_q == payload_q - PAY_W'(1));
    end
endmodule

// File: rtl/bts_ctrl.sv
// Transfer sequencer: accepts start, walks packets, waits for ack or retry.
// Assumes ack and retry are single-cycle pulses from the packet engine.
module bts_ctrl
    import bts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_bad,
    input  logic [MUL_W-1:0] pkt_count,
    input  logic             pkt_ready,
    input  logic             pkt_ack,
    input  logic             pkt_retry,
    input  logic             last_beat,
    output logic             busy,
    output logic             pkt_valid,
    output logic             pkt_last,
    output logic             tx_done,
    output logic             cfg_err,
    output logic             load,
    output logic             beat,
    output logic             rewind,
    output logic             advance
);
    bts_state_e       state_q;
    logic [MUL_W-1:0] idx_q;
    logic [MUL_W-1:0] count_q;
    logic             final_pkt;

    // Strobes toward the address generator and handshake outputs.
    always_comb begin
        final_pkt = (idx_q == count_q - MUL_W'(1));
        busy      = (state_q != ST_IDLE);
        pkt_valid = (state_q == ST_SEND);
        pkt_last  = pkt_valid && last_beat;
        load      = (state_q == ST_IDLE) && start && !cfg_bad;
        beat      = pkt_valid && pkt_ready;
        advance   = (state_q == ST_WAIT) && pkt_ack && !final_pkt;
        rewind    = (state_q == ST_WAIT) && !pkt_ack && pkt_retry;
    end

    // State, packet index, latched count, error flag and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            count_q <= '0;
            cfg_err <= 1'b0;
            tx_done <= 1'b0;
        end else begin
            tx_done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_err <= cfg_bad;
                        if (!cfg_bad) begin
                            state_q <= ST_SEND;
                            idx_q   <= '0;
                            count_q <= pkt_count;
                        end
                    end
                end
                ST_SEND: begin
                    if (pkt_ready && last_beat) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (pkt_ack) begin
                        if (final_pkt) begin
                            state_q <= ST_IDLE;
                            tx_done <= 1'b1;
                        end else begin
                            idx_q   <= idx_q + MUL_W'(1);
                            state_q <= ST_SEND;
                        end
                    end else if (pkt_retry) begin
                        state_q <= ST_SEND;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bulk_tx_splitter.sv
// Top of the bulk transmit splitter: cuts one stored block into bus packets.
// Assumes the buffer read is asynchronous (data valid in the addressed cycle).
module bulk_tx_splitter
    import bts_pkg::*;
#(
    parameter int FIFO_DEPTH = 512,
    localparam int AW = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_maxp,
    input  logic              cfg_bulk,
    input  logic              start,
    output logic              busy,
    output logic              cfg_err,
    output logic              tx_done,
    output logic [AW-1:0]     fifo_rd_addr,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic              pkt_valid,
    output logic [DATA_W-1:0] pkt_data,
    output logic              pkt_last,
    input  logic              pkt_ready,
    input  logic              pkt_ack,
    input  logic              pkt_retry
);
    logic [PAY_W-1:0] payload;
    logic [MUL_W-1:0] pkt_count;
    logic             cfg_bad;
    logic             load;
    logic             beat;
    logic             rewind;
    logic             advance;
    logic             last_beat;

    bts_cfg_decode #(.FIFO_DEPTH(FIFO_DEPTH)) u_decode (
        .cfg_word  (cfg_maxp),
        .is_bulk   (cfg_bulk),
        .payload   (payload),
        .pkt_count (pkt_count),
        .cfg_bad   (cfg_bad)
    );

    bts_addr_gen #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .payload_in (payload),
        .beat       (beat),
        .rewind     (rewind),
        .advance    (advance),
        .addr       (fifo_rd_addr),
        .last_beat  (last_beat)
    );

    bts_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_bad   (cfg_bad),
        .pkt_count (pkt_count),
        .pkt_ready (pkt_ready),
        .pkt_ack   (pkt_ack),
        .pkt_retry (pkt_retry),
        .last_beat (last_beat),
        .busy      (busy),
        .pkt_valid (pkt_valid),
        .pkt_last  (pkt_last),
        .tx_done   (tx_done),
        .cfg_err   (cfg_err),
        .load      (load),
        .beat      (beat),
        .rewind    (rewind),
        .advance   (advance)
    );

    // Byte path: the addressed buffer byte goes straight to the engine.
    assign pkt_data = fifo_rd_data;
endmodule

// File: rtl/bts_checker.sv
// Cycle-level rules of the splitter's handshake, attached by bind.
module bts_checker #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          cfg_err,
    input logic          tx_done,
    input logic [AW-1:0] fifo_rd_addr,
    input logic          pkt_valid,
    input logic          pkt_last,
    input logic          pkt_ready
);
    assert_last_in_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_last |-> pkt_valid);

    assert_gap_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && pkt_last) |=> !pkt_valid);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !busy);

    assert_err_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> !busy);

    assert_idle_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pkt_valid);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(fifo_rd_addr)));
endmodule

bind bulk_tx_splitter bts_checker #(.AW(AW)) u_bts_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .cfg_err      (cfg_err),
    .tx_done      (tx_done),
    .fifo_rd_addr (fifo_rd_addr),
    .pkt_valid    (pkt_valid),
    .pkt_last     (pkt_last),
    .pkt_ready    (pkt_ready)
);

// File: tb/test_bulk_tx_splitter.sv
module test_bulk_tx_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 512;
    localparam int AW         = $clog2(DEPTH);
    localparam int NV         = 12;

    typedef struct packed {
        logic [15:0] maxp;
        logic        bulk;
        logic        err;
        logic [7:0]  req;
        logic [5:0]  npkt;
        logic [11:0] len;
        logic        stall;
        logic [5:0]  retry;
    } vec_t;

    // maxp, bulk, err, requirement, packets, length, stall, retry packet (63 none)
    localparam vec_t VECS [NV] = '{
        '{16'h2008, 1'b1, 1'b0, 8'd1, 6'd4,  12'd8,   1'b0, 6'd63}, // R1 split 4x8
        '{16'h1040, 1'b1, 1'b0, 8'd7, 6'd2,  12'd64,  1'b0, 6'd1 }, // R7 retry pkt 1
        '{16'h4040, 1'b1, 1'b0, 8'd5, 6'd8,  12'd64,  1'b0, 6'd63}, // R5 exactly full
        '{16'h0064, 1'b0, 1'b0, 8'd1, 6'd1,  12'd100, 1'b0, 6'd63}, // R1 mult 0, not bulk
        '{16'h080D, 1'b1, 1'b0, 8'd7, 6'd1,  12'd13,  1'b1, 6'd0 }, // R7 mult 1, stall, retry
        '{16'h180C, 1'b1, 1'b1, 8'd4, 6'd0,  12'd0,   1'b0, 6'd63}, // R4 payload 12
        '{16'h1010, 1'b0, 1'b1, 8'd3, 6'd0,  12'd0,   1'b0, 6'd63}, // R3 not bulk
        '{16'h8040, 1'b1, 1'b1, 8'd5, 6'd0,  12'd0,   1'b0, 6'd63}, // R5 1024 bytes
        '{16'h0258, 1'b0, 1'b1, 8'd5, 6'd0,  12'd0,   1'b0, 6'd63}, // R5 600 bytes
        '{16'h2000, 1'b1, 1'b1, 8'd5, 6'd0,  12'd0,   1'b0, 6'd63}, // R5 payload 0
        '{16'hF810, 1'b1, 1'b0, 8'd1, 6'd31, 12'd16,  1'b0, 6'd63}, // R1 31 packets
        '{16'h1020, 1'b1, 1'b0, 8'd11,6'd2,  12'd32,  1'b1, 6'd63}  // R11 stalled
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cfg_maxp = '0;
    logic          cfg_bulk = 1'b0;
    logic          start = 1'b0;
    logic          busy, cfg_err, tx_done;
    logic [AW-1:0] fifo_rd_addr;
    logic [7:0]    fifo_rd_data;
    logic          pkt_valid, pkt_last;
    logic [7:0]    pkt_data;
    logic          pkt_ready = 1'b0;
    logic          pkt_ack = 1'b0;
    logic          pkt_retry = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    int done_seen = 0;
    int cycles = 0;

    function automatic logic [7:0] ref_byte(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    assign fifo_rd_data = ref_byte(int'(fifo_rd_addr));

    always #(CLK_PERIOD / 2) clk = ~clk;

    bulk_tx_splitter #(.FIFO_DEPTH(DEPTH)) i_bulk_tx_splitter (
        .clk(clk), .rst_n(rst_n), .cfg_maxp(cfg_maxp), .cfg_bulk(cfg_bulk),
        .start(start), .busy(busy), .cfg_err(cfg_err), .tx_done(tx_done),
        .fifo_rd_addr(fifo_rd_addr), .fifo_rd_data(fifo_rd_data),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_last(pkt_last),
        .pkt_ready(pkt_ready), .pkt_ack(pkt_ack), .pkt_retry(pkt_retry)
    );

    always @(negedge clk) if (tx_done) done_seen++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    // Collects one packet; returns bytes seen, data errors and last errors.
    task automatic collect(input int base, input int len, input bit stall,
                           output int got, output int bad_data, output int bad_last);
        int guard = 0;
        got = 0; bad_data = 0; bad_last = 0;
        while (got < len && guard < 5000) begin
            @(negedge clk);
            pkt_ready = stall ? ~pkt_ready : 1'b1;
            #1;
            if (pkt_valid && pkt_ready) begin
                if (pkt_data !== ref_byte(base + got)) bad_data++;
                if (pkt_last !== (got == len - 1)) bad_last++;
                got++;
            end
            guard++;
        end
        @(negedge clk);
        pkt_ready = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit poke);
        string tag;
        int got, bd, bl;
        bit retried = 1'b0;
        tag = $sformatf("R%0d", v.req);
        done_seen = 0;
        @(negedge clk);
        cfg_maxp = v.maxp; cfg_bulk = v.bulk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check(cfg_err == v.err, tag, cfg_err, v.err);
        if (v.err) begin
            check(!busy && !pkt_valid, "R5", busy, 0);
            return;
        end
        check(busy, "R1", busy, 1);
        for (int p = 0; p < int'(v.npkt); p++) begin
            collect(p * int'(v.len), int'(v.len), v.stall, got, bd, bl);
            check(got == int'(v.len), "R1", got, v.len);
            check(bd == 0, "R2", bd, 0);
            check(bl == 0, "R2", bl, 0);
            @(negedge clk); #1;
            check(!pkt_valid && busy, "R6", pkt_valid, 0);
            if (poke && p == 0) begin
                cfg_maxp = 16'h180C; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                #1;
                check(!cfg_err && busy && !pkt_valid, "R9", cfg_err, 0);
            end
            if (p == int'(v.retry) && !retried) begin
                retried = 1'b1;
                pkt_retry = 1'b1;
                @(negedge clk);
                pkt_retry = 1'b0;
                collect(p * int'(v.len), int'(v.len), v.stall, got, bd, bl);
                check(got == int'(v.len) && bd == 0 && bl == 0, "R7", bd + bl, 0);
                @(negedge clk);
            end
            pkt_ack = 1'b1;
            @(negedge clk);
            pkt_ack = 1'b0;
            #1;
            if (p == int'(v.npkt) - 1) begin
                check(tx_done && !busy, "R8", tx_done, 1);
            end else begin
                check(!tx_done && busy, "R8", tx_done, 0);
            end
        end
        @(negedge clk); #1;
        check(done_seen == 1 && !tx_done && !pkt_valid, "R8", done_seen, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check(!busy && !cfg_err && !tx_done && !pkt_valid, "R10", busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R9 start while busy is ignored and the latched config kept
        run_vec('{16'h1008, 1'b1, 1'b0, 8'd9, 6'd2, 12'd8, 1'b0, 6'd63}, 1'b1);

        // R10 reset in the middle of a transfer
        @(negedge clk);
        cfg_maxp = 16'h2010; cfg_bulk = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk); #1;
        check(!busy && !pkt_valid && !tx_done, "R10", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk); #1;
        check(!busy && !pkt_valid, "R10", pkt_valid, 0);

        // R5 error flag cleared by the next legal start
        run_vec('{16'h0000, 1'b1, 1'b1, 8'd5, 6'd0, 12'd0, 1'b0, 6'd63}, 1'b0);
        run_vec('{16'h0005, 1'b0, 1'b0, 8'd5, 6'd1, 12'd5, 1'b0, 6'd63}, 1'b0);

        summary();
    end
endmodule